// File: doc/BRIEF.md
# Dual-Port Address Collision Detector with Capture Register

This block watches the registered accesses of the two ports of a shared memory and flags every cycle in which both ports touch the same address while at least one of them writes. For each such collision it pulses a busy flag toward the port whose read data cannot be trusted. If one port writes and the other reads, only the reader is flagged. If both write, both are flagged. The flags leave the block aligned with the read data of the colliding cycle, so the requesting logic can discard that word.

The first colliding address seen while the capture logic is armed is held in a capture register. Later collisions still raise busy flags but leave the register alone. A readback request returns the held address with the same latency as a memory read. It also re-arms the capture logic after a two-cycle hold-off, so a collision in the request cycle or in the cycle after it is not captured. The read latency `RD_LAT` is either 1 or 2, to match the memory's flow-through or pipelined mode.

Top module: `coll_detect`

## Requirements
- R1: A collision exists in a cycle only when both ports are valid, both addresses are equal and at least one port writes. Two reads of the same address, a mismatch, or an idle port give no busy flag.
- R2: When one port writes and the other reads the colliding address, only the reading port's busy flag is raised.
- R3: When both ports write the same address, both busy flags are raised.
- R4: The busy flags for the inputs sampled on rising edge k appear after rising edge k+RD_LAT-1 (RD_LAT registers, the sampling edge counted) and last one cycle. They are low in any cycle whose sampled inputs hold no collision.
- R5: While armed, the address of the first collision is stored in the capture register, and capture stops.
- R6: Later collisions do not overwrite the stored address until a readback re-arms the logic.
- R7: A readback request sampled on edge k drives `rb_vld` high for one cycle, with `rb_addr` equal to the stored address as it was before that edge, on the same cycle that busy flags for edge k appear.
- R8: After a readback sampled on edge r, collisions sampled on edges r and r+1 are not captured. The first collision sampled on edge r+2 or later is captured.
- R9: Reset clears the stored address to zero, arms the capture logic and holds `a_busy`, `b_busy` and `rb_vld` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_vld | input | 1 | Port A access valid |
| a_wr | input | 1 | Port A access is a write |
| a_addr | input | ADDR_W | Port A address |
| b_vld | input | 1 | Port B access valid |
| b_wr | input | 1 | Port B access is a write |
| b_addr | input | ADDR_W | Port B address |
| rb_req | input | 1 | Request to read back the captured address |
| a_busy | output | 1 | Port A read data of that cycle may be corrupt |
| b_busy | output | 1 | Port B read data of that cycle may be corrupt |
| rb_vld | output | 1 | Readback result valid |
| rb_addr | output | ADDR_W | Captured collision address |

## Verification
The bench sweeps every combination of valid and write for both ports against every address pair of a 3-bit configuration. This catches a detector that flags two reads, flags the writer rather than the reader, or misses one flag when both ports write. Directed runs place collisions after a capture, so a design that overwrites on every collision returns the wrong address. Other runs place collisions in the readback cycle, one cycle after it and two cycles after it, so a hold-off that is too short or too long captures the wrong address. Readbacks are also checked right after reset and in the same cycle as a collision, which exposes a register that does not clear or a readback that returns the value after the update.

// File: rtl/coll_pkg.sv
package coll_pkg;

    typedef enum logic [1:0] {
        CAP_ARMED   = 2'd0,
        CAP_HOLDOFF = 2'd1,
        CAP_LOCKED  = 2'd2
    } cap_state_e;

endpackage

// File: rtl/coll_match.sv
module coll_match #(
    parameter int ADDR_W = 16
) (
    input  logic              a_vld,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_vld,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              hit,
    output logic              flag_a,
    output logic              flag_b
);

    logic same_addr;
    logic both_live;

    always_comb begin
        same_addr = (a_addr == b_addr);
        both_live = a_vld && b_vld;
        hit       = both_live && same_addr && (a_wr || b_wr);
        // the port hurt is the one facing a writer on the other side
        flag_a    = hit && b_wr;
        flag_b    = hit && a_wr;
    end

endmodule

// File: rtl/coll_capture.sv
module coll_capture
    import coll_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic              rb_req,
    output logic [ADDR_W-1:0] held_addr,
    output logic              locked
);

    typedef struct packed {
        cap_state_e        state;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q;

    always_comb begin
        cap_d = cap_q;
        if (rb_req) begin
            cap_d.state = CAP_HOLDOFF;
        end else begin
            unique case (cap_q.state)
                CAP_ARMED: begin
                    if (hit) begin
                        cap_d.state = CAP_LOCKED;
                        cap_d.addr  = hit_addr;
                    end
                end
                CAP_HOLDOFF: cap_d.state = CAP_ARMED;
                CAP_LOCKED:  cap_d.state = CAP_LOCKED;
                default:     cap_d.state = CAP_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{state: CAP_ARMED, addr: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign held_addr = cap_q.addr;
    assign locked    = (cap_q.state == CAP_LOCKED);

endmodule

// File: rtl/coll_delay.sv
module coll_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [DEPTH];
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/coll_detect.sv
module coll_detect #(
    parameter int ADDR_W = 16,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_vld,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_vld,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              rb_req,
    output logic              a_busy,
    output logic              b_busy,
    output logic              rb_vld,
    output logic [ADDR_W-1:0] rb_addr
);

    localparam int PIPE_W = ADDR_W + 3;
    localparam int DEPTH  = (RD_LAT < 2) ? 1 : 2;

    typedef struct packed {
        logic              busy_a;
        logic              busy_b;
        logic              rb;
        logic [ADDR_W-1:0] addr;
    } out_t;

    logic              hit;
    logic              flag_a;
    logic              flag_b;
    logic [ADDR_W-1:0] held_addr;
    logic              cap_locked;
    out_t              out_d;
    out_t              out_q;

    coll_match #(.ADDR_W(ADDR_W)) u_match (
        .a_vld  (a_vld),
        .a_wr   (a_wr),
        .a_addr (a_addr),
        .b_vld  (b_vld),
        .b_wr   (b_wr),
        .b_addr (b_addr),
        .hit    (hit),
        .flag_a (flag_a),
        .flag_b (flag_b)
    );

    coll_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .hit_addr  (a_addr),
        .rb_req    (rb_req),
        .held_addr (held_addr),
        .locked    (cap_locked)
    );

    // readback shows the register content before this cycle's update
    always_comb begin
        out_d.busy_a = flag_a;
        out_d.busy_b = flag_b;
        out_d.rb     = rb_req;
        out_d.addr   = rb_req ? held_addr : '0;
    end

    coll_delay #(.WIDTH(PIPE_W), .DEPTH(DEPTH)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (out_d),
        .dout  (out_q)
    );

    assign a_busy  = out_q.busy_a;
    assign b_busy  = out_q.busy_b;
    assign rb_vld  = out_q.rb;
    assign rb_addr = out_q.addr;

endmodule

module coll_detect_chk #(
    parameter int ADDR_W = 16,
    parameter int RD_LAT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_vld,
    input logic              a_wr,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_vld,
    input logic              b_wr,
    input logic [ADDR_W-1:0] b_addr,
    input logic              rb_req,
    input logic              a_busy,
    input logic              b_busy,
    input logic              rb_vld,
    input logic              cap_locked,
    input logic [ADDR_W-1:0] held_addr
);

    localparam int LAT = (RD_LAT < 2) ? 1 : 2;

    assert_reads_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (a_busy || b_busy) |-> $past(a_vld && b_vld && (a_wr || b_wr), LAT));

    assert_a_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        a_busy |-> $past(b_vld && b_wr && a_vld && (a_addr == b_addr), LAT));

    assert_b_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        b_busy |-> $past(a_vld && a_wr && b_vld && (a_addr == b_addr), LAT));

    assert_dual_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_busy && b_busy) |-> $past(a_wr && b_wr, LAT));

    assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_locked && $past(cap_locked)) |-> $stable(held_addr));

    assert_rb_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rb_vld |-> $past(rb_req, LAT));

    assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rb_req) |-> !cap_locked);

endmodule

bind coll_detect coll_detect_chk #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_vld      (a_vld),
    .a_wr       (a_wr),
    .a_addr     (a_addr),
    .b_vld      (b_vld),
    .b_wr       (b_wr),
    .b_addr     (b_addr),
    .rb_req     (rb_req),
    .a_busy     (a_busy),
    .b_busy     (b_busy),
    .rb_vld     (rb_vld),
    .cap_locked (cap_locked),
    .held_addr  (held_addr)
);

// File: tb/tb_coll_detect.sv
module tb_coll_detect;

    localparam int AW  = 3;
    localparam int LAT = 2;
    localparam int NBUF = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_vld = 1'b0, a_wr = 1'b0, b_vld = 1'b0, b_wr = 1'b0, rb_req = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic          a_busy, b_busy, rb_vld;
    logic [AW-1:0] rb_addr;

    int total = 0;
    int fails = 0;
    int ncyc  = 0;

    // bench model of the capture behaviour: 0 armed, 1 hold-off, 2 locked
    int            m_state = 0;
    logic [AW-1:0] m_addr  = '0;

    logic          e_a   [NBUF];
    logic          e_b   [NBUF];
    logic          e_rv  [NBUF];
    logic [AW-1:0] e_ra  [NBUF];
    string         e_tag [NBUF];
    string         e_rtag[NBUF];

    always #5 clk = ~clk;

    coll_detect #(.ADDR_W(AW), .RD_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_vld(a_vld), .a_wr(a_wr), .a_addr(a_addr),
        .b_vld(b_vld), .b_wr(b_wr), .b_addr(b_addr),
        .rb_req(rb_req),
        .a_busy(a_busy), .b_busy(b_busy), .rb_vld(rb_vld), .rb_addr(rb_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic av, input logic aw, input logic [AW-1:0] aa,
                        input logic bv, input logic bw, input logic [AW-1:0] ba,
                        input logic rb, input string rtag);
        int  idx;
        bit  m;
        a_vld = av; a_wr = aw; a_addr = aa;
        b_vld = bv; b_wr = bw; b_addr = ba; rb_req = rb;
        idx = ncyc % NBUF;
        m = av && bv && (aw || bw) && (aa == ba);
        e_a[idx]    = m && bw;
        e_b[idx]    = m && aw;
        e_rv[idx]   = rb;
        e_ra[idx]   = m_addr;
        e_rtag[idx] = rtag;
        if (m) e_tag[idx] = (aw && bw) ? "R3" : "R2";
        else   e_tag[idx] = (av && bv && aa == ba) ? "R1" : "R4";
        if (rb) begin
            m_state = 1;
        end else if (m_state == 0) begin
            if (m) begin m_state = 2; m_addr = aa; end
        end else if (m_state == 1) begin
            m_state = 0;
        end
        @(posedge clk);
        ncyc++;
        @(negedge clk);
        if (ncyc >= LAT) begin
            idx = (ncyc - LAT) % NBUF;
            chk(a_busy == e_a[idx], e_tag[idx], "a_busy", int'(a_busy), int'(e_a[idx]));
            chk(b_busy == e_b[idx], e_tag[idx], "b_busy", int'(b_busy), int'(e_b[idx]));
            chk(rb_vld == e_rv[idx], "R7", "rb_vld", int'(rb_vld), int'(e_rv[idx]));
            if (e_rv[idx])
                chk(rb_addr == e_ra[idx], e_rtag[idx], "rb_addr", int'(rb_addr), int'(e_ra[idx]));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, '0, 0, "R7");
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(a_busy == 1'b0, "R9", "a_busy in reset", int'(a_busy), 0);
        chk(b_busy == 1'b0, "R9", "b_busy in reset", int'(b_busy), 0);
        chk(rb_vld == 1'b0, "R9", "rb_vld in reset", int'(rb_vld), 0);
        rst_n = 1'b1;

        // readback right after reset returns zero (R9)
        step(0, 0, '0, 0, 0, '0, 1, "R9");
        idle(3);

        // R5: first collision captured
        step(1, 1, 3'd5, 1, 0, 3'd5, 0, "R5");
        idle(1);
        step(0, 0, '0, 0, 0, '0, 1, "R5");
        idle(3);

        // R6: first of two collisions kept
        step(1, 0, 3'd4, 1, 1, 3'd4, 0, "R6");
        step(1, 1, 3'd2, 1, 1, 3'd2, 0, "R6");
        step(1, 1, 3'd7, 1, 0, 3'd7, 0, "R6");
        step(0, 0, '0, 0, 0, '0, 1, "R6");

        // R8: collision at r+1 ignored, r+2 captured
        step(1, 1, 3'd1, 1, 0, 3'd1, 0, "R8");
        step(1, 0, 3'd6, 1, 1, 3'd6, 0, "R8");
        idle(2);
        step(0, 0, '0, 0, 0, '0, 1, "R8");
        // collision in the readback cycle itself ignored
        step(1, 1, 3'd3, 1, 1, 3'd3, 1, "R8");
        idle(1);
        step(1, 1, 3'd2, 1, 0, 3'd2, 0, "R8");
        idle(1);
        step(0, 0, '0, 0, 0, '0, 1, "R8");
        idle(2);

        // exhaustive sweep over controls and address pairs
        for (int c = 0; c < 16; c++) begin
            for (int x = 0; x < 8; x++) begin
                for (int y = 0; y < 8; y++) begin
                    step(c[0], c[1], x[AW-1:0], c[2], c[3], y[AW-1:0],
                         ((c * 64 + x * 8 + y) % 37) == 36, "R7");
                end
            end
        end
        idle(LAT + 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule